// File: doc/BRIEF.md
# DMA Bus Handover Sequencer

This block runs the bus-ownership handshake for a small DMA controller. Several peripherals can request service at once. The sequencer chooses one of them, asks the host processor for its buses, and waits for the processor to give them up. It then acknowledges the chosen peripheral and produces the per-byte control strobes that move data between memory and the I/O port. When the service finishes, it hands the buses back.

Address and count arithmetic live in a separate channel engine. That engine sees a one-cycle step pulse for each byte that completes. It answers with a done level when the byte in flight is the last one.

Some channels can be set up by parameter as cascade channels. On a cascade channel, the request and acknowledge pins connect to the hold request and hold acknowledge of a secondary controller. The sequencer only passes the processor's grant along and drives nothing on the bus itself.

Top module: `dma_handover_seq`

## Requirements
- R1: After reset, and for as long as no unmasked request is present, `hold_req`, every bit of `chan_ack`, `addr_en`, `addr_stb`, `mem_rd`, `mem_wr`, `io_rd`, `io_wr` and `byte_step` are all 0. A request whose `chan_mask` bit is 1 never starts a service.
- R2: An unmasked request sampled while idle raises `hold_req` in the next cycle. If several unmasked requests are present, the channel with the lowest index wins.
- R3: While `hold_req` is 1 and `hold_ack` has not yet been sampled high, `chan_ack`, `addr_en` and all strobes stay 0, however long the wait lasts.
- R4: From the cycle after `hold_ack` is sampled high until release, `chan_ack` is one-hot on the winning channel. `hold_req` stays 1 for the whole service.
- R5: Each byte on a normal channel takes exactly four cycles, in this order: address setup (`addr_stb` = 1), read strobe, write strobe, recovery (`byte_step` = 1). `addr_en` is 1 in all four cycles.
- R6: `chan_dir` bit 1 means memory to peripheral: `mem_rd` is asserted in the read cycle and `io_wr` in the write cycle. Bit 0 means peripheral to memory: `io_rd` is asserted, then `mem_wr`. At most one strobe is active at a time.
- R7: At the end of recovery, the sequencer checks three inputs. If `xfer_done` is 1, or the winner's request is 0, the service ends. Otherwise the next byte starts with address setup. When the service ends, `hold_req` and `chan_ack` are 0 in the following cycle, and a new request may then start a fresh service.
- R8: The winner is chosen only while idle. New requests from other channels, and changes to `chan_mask`, during a service do not change `chan_ack`.
- R9: If `hold_ack` falls at any point during a byte, that byte still completes all four cycles. The bus is then released after recovery, whatever `xfer_done` and the request are doing.
- R10: A channel whose bit is set in `CASCADE_MASK` (default: channel 3) gets `chan_ack` after `hold_ack` in the same way as other channels. It never sees `addr_en`, `addr_stb` or any strobe. Its service ends in the cycle after its request or `hold_ack` is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_req | input | NUM_CH | Per-channel service request |
| chan_mask | input | NUM_CH | Per-channel disable, 1 = ignore the request |
| chan_dir | input | NUM_CH | Per-channel direction, 1 = memory to peripheral |
| xfer_done | input | 1 | From the channel engine: the current byte is the last |
| hold_ack | input | 1 | Bus grant from the host processor |
| hold_req | output | 1 | Bus request to the host processor |
| chan_ack | output | NUM_CH | One-hot acknowledge to the serviced channel |
| addr_en | output | 1 | Takes the address bus from the processor |
| addr_stb | output | 1 | Latches the upper address bits for the byte |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Peripheral read strobe |
| io_wr | output | 1 | Peripheral write strobe |
| byte_step | output | 1 | One pulse per completed byte, for the channel engine |

## Verification
The bench sweeps every combination of request and mask pattern on four channels, and the expected winner is computed as the lowest set bit. A wrong priority encoder, or one that forgets the mask, acknowledges the wrong channel in this sweep. Each case holds off the grant for a varying number of cycles and, during the first byte, raises a higher-priority request. A design that strobes early would be caught during the hold-off, and one that re-arbitrates mid-service would move `chan_ack` when the new request arrives. Directed cases cover multi-byte services that end on done, a request dropped at recovery, grant loss in the middle of a byte (a wrong design would cut the byte short or carry on into the next one), and the cascade channel, which must never drive strobes.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WAIT  = 3'd1,
      ST_ADDR  = 3'd2,
      ST_READ  = 3'd3,
      ST_WRITE = 3'd4,
      ST_RECOV = 3'd5,
      ST_CASC  = 3'd6
   } hs_state_e;
endpackage

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
   parameter int NUM_CH = 4,
   localparam int SEL_W = $clog2(NUM_CH)
) (
   input  logic [NUM_CH-1:0] cand,
   output logic              found,
   output logic [SEL_W-1:0]  idx
);
   // lowest index wins: scan downward so the last hit is the lowest
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (cand[i]) begin
            found = 1'b1;
            idx   = SEL_W'(i);
         end
      end
   end
endmodule

// File: rtl/dma_strobe_dec.sv
module dma_strobe_dec
   import dma_hs_pkg::*;
(
   input  hs_state_e state,
   input  logic      mem_to_io,
   output logic      addr_en,
   output logic      addr_stb,
   output logic      mem_rd,
   output logic      mem_wr,
   output logic      io_rd,
   output logic      io_wr,
   output logic      byte_step
);
   logic rd_phase, wr_phase;

   always_comb begin
      rd_phase  = (state == ST_READ);
      wr_phase  = (state == ST_WRITE);
      addr_en   = (state == ST_ADDR) || rd_phase || wr_phase || (state == ST_RECOV);
      addr_stb  = (state == ST_ADDR);
      byte_step = (state == ST_RECOV);
      mem_rd    = rd_phase &&  mem_to_io;
      io_rd     = rd_phase && !mem_to_io;
      io_wr     = wr_phase &&  mem_to_io;
      mem_wr    = wr_phase && !mem_to_io;
   end
endmodule

// File: rtl/dma_handover_seq.sv
module dma_handover_seq
   import dma_hs_pkg::*;
#(
   parameter int              NUM_CH       = 4,
   parameter logic [NUM_CH-1:0] CASCADE_MASK = 4'b1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] chan_req,
   input  logic [NUM_CH-1:0] chan_mask,
   input  logic [NUM_CH-1:0] chan_dir,
   input  logic              xfer_done,
   input  logic              hold_ack,
   output logic              hold_req,
   output logic [NUM_CH-1:0] chan_ack,
   output logic              addr_en,
   output logic              addr_stb,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              io_rd,
   output logic              io_wr,
   output logic              byte_step
);
   localparam int SEL_W = $clog2(NUM_CH);

   generate
      if (NUM_CH < 2 || NUM_CH > 8) begin : g_bad_cfg
         $fatal(1, "dma_handover_seq: NUM_CH must be 2..8");
      end
   endgenerate

   hs_state_e        state_q, state_d;
   logic [SEL_W-1:0] sel_q;
   logic             lost_q;
   logic             pick_found;
   logic [SEL_W-1:0] pick_idx;
   logic             in_byte, ack_phase, lost_now, end_byte;

   dma_prio_pick #(.NUM_CH(NUM_CH)) u_pick (
      .cand  (chan_req & ~chan_mask),
      .found (pick_found),
      .idx   (pick_idx)
   );

   always_comb begin
      in_byte   = (state_q == ST_ADDR) || (state_q == ST_READ) ||
                  (state_q == ST_WRITE) || (state_q == ST_RECOV);
      ack_phase = in_byte || (state_q == ST_CASC);
      lost_now  = lost_q || !hold_ack;
      end_byte  = lost_now || xfer_done || !chan_req[sel_q];
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (pick_found) state_d = ST_WAIT;
         ST_WAIT:  if (hold_ack)   state_d = CASCADE_MASK[sel_q] ? ST_CASC : ST_ADDR;
         ST_ADDR:  state_d = ST_READ;
         ST_READ:  state_d = ST_WRITE;
         ST_WRITE: state_d = ST_RECOV;
         ST_RECOV: state_d = end_byte ? ST_IDLE : ST_ADDR;
         ST_CASC:  if (!hold_ack || !chan_req[sel_q]) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sel_q   <= '0;
         lost_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && pick_found) sel_q <= pick_idx;
         if (state_d == ST_IDLE)               lost_q <= 1'b0;
         else if (in_byte && !hold_ack)        lost_q <= 1'b1;
      end
   end

   assign hold_req = (state_q != ST_IDLE);

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_ack
         assign chan_ack[g] = ack_phase && (sel_q == SEL_W'(g));
      end
   endgenerate

   dma_strobe_dec u_dec (
      .state     (state_q),
      .mem_to_io (chan_dir[sel_q]),
      .addr_en   (addr_en),
      .addr_stb  (addr_stb),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .io_rd     (io_rd),
      .io_wr     (io_wr),
      .byte_step (byte_step)
   );
endmodule

// File: rtl/dma_handover_chk.sv
module dma_handover_chk #(
   parameter int                NUM_CH       = 4,
   parameter logic [NUM_CH-1:0] CASCADE_MASK = 4'b1000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hold_ack,
   input logic              hold_req,
   input logic [NUM_CH-1:0] chan_ack,
   input logic              addr_en,
   input logic              addr_stb,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic              io_rd,
   input logic              io_wr,
   input logic              byte_step
);
   logic any_strobe;
   assign any_strobe = mem_rd | mem_wr | io_rd | io_wr;

   // R3: the bus is taken only after the grant was seen
   p_aen_after_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(addr_en) |-> $past(hold_ack));

   // R4: acknowledge is one-hot and only inside a hold
   p_ack_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chan_ack));
   p_ack_in_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|chan_ack) |-> hold_req);

   // R5: strobe after address setup, step after write
   p_read_after_stb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      addr_stb |=> (mem_rd || io_rd));
   p_step_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      byte_step |-> $past(mem_wr || io_wr));

   // R6: strobes exclusive and only with the address bus owned
   p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({mem_rd, mem_wr, io_rd, io_wr}) <= 1);
   p_strobe_needs_aen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      any_strobe |-> addr_en);

   // R8: the acknowledged channel does not move during a service
   p_ack_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((|chan_ack) && $past(|chan_ack)) |-> $stable(chan_ack));

   // R10: a cascade channel never sees bus control
   p_casc_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (|(chan_ack & CASCADE_MASK)) |-> !(addr_en || any_strobe));
endmodule

bind dma_handover_seq dma_handover_chk #(
   .NUM_CH(NUM_CH), .CASCADE_MASK(CASCADE_MASK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .hold_ack(hold_ack), .hold_req(hold_req),
   .chan_ack(chan_ack), .addr_en(addr_en), .addr_stb(addr_stb),
   .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
   .byte_step(byte_step)
);

// File: tb/test_dma_handover_seq.sv
`timescale 1ns/1ps
module test_dma_handover_seq;
   localparam int         N    = 4;
   localparam logic [3:0] CASC = 4'b1000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [N-1:0] chan_req = '0, chan_mask = '0, chan_dir = '0;
   logic xfer_done = 1'b0, hold_ack = 1'b0;
   logic hold_req, addr_en, addr_stb, mem_rd, mem_wr, io_rd, io_wr, byte_step;
   logic [N-1:0] chan_ack;

   int checks = 0, errors = 0, cycles = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   dma_handover_seq #(.NUM_CH(N), .CASCADE_MASK(CASC)) i_dma_handover_seq (
      .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .chan_mask(chan_mask),
      .chan_dir(chan_dir), .xfer_done(xfer_done), .hold_ack(hold_ack),
      .hold_req(hold_req), .chan_ack(chan_ack), .addr_en(addr_en),
      .addr_stb(addr_stb), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd),
      .io_wr(io_wr), .byte_step(byte_step)
   );

   // {hold_req, chan_ack, addr_en, addr_stb, mem_rd, mem_wr, io_rd, io_wr, byte_step}
   function automatic logic [11:0] pack_out();
      return {hold_req, chan_ack, addr_en, addr_stb, mem_rd, mem_wr, io_rd, io_wr, byte_step};
   endfunction

   task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%03h expected=%03h", tag, act, exp);
      end
   endtask

   function automatic logic [11:0] expo(input bit hr, input logic [3:0] ack, input bit aen,
                                        input bit stb, input bit mr, input bit mw,
                                        input bit ir, input bit iw, input bit st);
      return {hr, ack, aen, stb, mr, mw, ir, iw, st};
   endfunction

   task automatic tick();
      @(negedge clk);
   endtask

   // one byte on a normal channel; enters in address setup, leaves after recovery edge
   task automatic one_byte(input int w, input bit d, input bit last, input bit drop_ack);
      logic [3:0] a;
      a = 4'(1 << w);
      check("R5 address setup", pack_out(), expo(1, a, 1, 1, 0, 0, 0, 0, 0));
      if (w != 0) chan_req[0] = 1'b1;   // R8: higher-priority request mid-service
      chan_mask = ~chan_mask;            // R8: mask change mid-service
      if (drop_ack) hold_ack = 1'b0;     // R9
      tick();
      check("R6 read cycle", pack_out(), expo(1, a, 1, 0, d, 0, !d, 0, 0));
      tick();
      check("R6 write cycle", pack_out(), expo(1, a, 1, 0, 0, !d, 0, d, 0));
      tick();
      check("R5 recovery", pack_out(), expo(1, a, 1, 0, 0, 0, 0, 0, 1));
      xfer_done = last;
      tick();
   endtask

   task automatic finish_idle(input string tag);
      check(tag, pack_out(), '0);
      chan_req = '0; hold_ack = 1'b0; xfer_done = 1'b0; chan_mask = '0;
      tick();
   endtask

   task automatic run_case(input logic [3:0] req, input logic [3:0] msk, input logic [3:0] dir,
                           input int waitn);
      logic [3:0] live;
      int w;
      live = req & ~msk;
      w = -1;
      for (int i = N - 1; i >= 0; i--) if (live[i]) w = i;
      chan_req = req; chan_mask = msk; chan_dir = dir; hold_ack = 1'b0; xfer_done = 1'b0;
      if (w < 0) begin
         repeat (3) tick();
         check("R1 masked request ignored", pack_out(), '0);
         chan_req = '0; chan_mask = '0;
         tick();
         return;
      end
      tick();
      check("R2 hold request raised", pack_out(), expo(1, 0, 0, 0, 0, 0, 0, 0, 0));
      repeat (waitn) tick();
      check("R3 no bus use before grant", pack_out(), expo(1, 0, 0, 0, 0, 0, 0, 0, 0));
      hold_ack = 1'b1;
      tick();
      if (CASC[w]) begin
         check("R10 cascade grant passed", pack_out(), expo(1, 4'(1 << w), 0, 0, 0, 0, 0, 0, 0));
         if (w != 0) chan_req[0] = 1'b1;
         tick();
         check("R10 cascade held", pack_out(), expo(1, 4'(1 << w), 0, 0, 0, 0, 0, 0, 0));
         chan_req[w] = 1'b0;
         tick();
         finish_idle("R10 cascade release on request drop");
      end else begin
         check("R4 winner acknowledged", {8'b0, chan_ack}, {8'b0, 4'(1 << w)});
         one_byte(w, dir[w], 1'b1, 1'b0);
         finish_idle("R7 release on done");
      end
   endtask

   initial begin
      repeat (3) tick();
      check("R1 reset state", pack_out(), '0);
      rst_n = 1'b1;
      tick();
      check("R1 idle after reset", pack_out(), '0);

      // sweep every request and mask pattern
      for (int r = 1; r < 16; r++)
         for (int m = 0; m < 16; m++)
            run_case(4'(r), 4'(m), 4'(m) ^ 4'b0101, (r + m) % 4);

      // R7: three bytes on channel 0, ending on done
      chan_req = 4'b0001; chan_dir = 4'b0001; tick();
      hold_ack = 1'b1; tick();
      one_byte(0, 1'b1, 1'b0, 1'b0);
      one_byte(0, 1'b1, 1'b0, 1'b0);
      one_byte(0, 1'b1, 1'b1, 1'b0);
      finish_idle("R7 release after third byte");

      // R7: request drops during second byte on channel 2
      chan_req = 4'b0100; chan_dir = 4'b0000; tick();
      hold_ack = 1'b1; tick();
      one_byte(2, 1'b0, 1'b0, 1'b0);
      check("R7 next byte follows", {11'b0, addr_stb}, 12'h001);
      chan_req[2] = 1'b0;
      one_byte(2, 1'b0, 1'b0, 1'b0);
      finish_idle("R7 release on request drop");

      // R9: grant lost in the middle of a byte on channel 1
      chan_req = 4'b0010; chan_dir = 4'b0010; tick();
      hold_ack = 1'b1; tick();
      one_byte(1, 1'b1, 1'b0, 1'b1);
      finish_idle("R9 release after grant loss");

      // R10: cascade released by grant loss
      chan_req = 4'b1000; tick();
      hold_ack = 1'b1; tick();
      check("R10 cascade grant", pack_out(), expo(1, 4'b1000, 0, 0, 0, 0, 0, 0, 0));
      hold_ack = 1'b0; tick();
      check("R10 cascade release on grant loss", pack_out(), '0);
      chan_req = '0; tick();

      // R7: a new service can start right after a release
      chan_req = 4'b0010; tick();
      check("R7 restart after release", pack_out(), expo(1, 0, 0, 0, 0, 0, 0, 0, 0));
      chan_req = '0;

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule